// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches a single 16-bit word from a serial EEPROM that uses a select line, a clock line driven by the master, a data line into the memory and a data line back out of it. A host presents a 6-bit word address together with a one-cycle start strobe. The block selects the memory, shifts out a 9-bit read command whose top three bits hold the read opcode and whose low six bits hold the address, then clocks in 16 data bits. It returns the assembled word with a one-cycle done pulse.

All serial timing is built from a time unit of `TICK_CLKS` system clocks. Every serial clock pulse is high for `HI_UNITS` units and low for `LO_UNITS` units (3 and 2 by default), so the serial clock is deliberately asymmetric. After the data phase the select line is dropped and one more clock pulse is issued with the memory deselected, which returns the memory's serial logic to its idle state before the next access.

Top module: `ee_word_reader`

## Requirements
- R1: While reset is asserted, and afterwards until a start is accepted, the select, serial clock and serial data-out lines are low, busy and done are low, and the returned word is zero; a reset in the middle of an access also clears the returned word.
- R2: Select rises while the serial clock and the memory data-in line are both low, and at least one time unit passes before the first serial clock rising edge.
- R3: On the first 9 serial clock rising edges of an access, the memory data-in line carries the command MSB first: bits 8:6 equal binary 110 and bits 5:0 equal the requested address.
- R4: The memory data-in line changes only while the serial clock is low; it is stable throughout every high phase.
- R5: Every serial clock pulse is high for exactly HI_UNITS x TICK_CLKS system clocks, and every low phase between two pulses of one access lasts exactly LO_UNITS x TICK_CLKS system clocks.
- R6: Once the high phase of the ninth command pulse ends, the memory data-in line stays low for the rest of the access.
- R7: The 16 data bits are taken from the memory data-out line in the last system clock of the high phase of pulses 10 to 25, MSB first, shifted in from the right; the result appears on the word output with done.
- R8: Each access issues exactly 26 serial clock pulses: 25 with select high, then select falls and one final pulse is issued with select low.
- R9: Busy is high from the cycle after an accepted start until done; done is a single-cycle pulse during which busy is already low, and the word output changes only at done.
- R10: A start strobe that arrives while busy is ignored: the access in flight keeps its original address, command and pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to read a word |
| addr_i | input | ADDR_W | Word address captured with start |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse, word valid |
| word_o | output | DATA_W | Last word read |
| ee_cs_o | output | 1 | Memory select |
| ee_sk_o | output | 1 | Serial clock to memory |
| ee_di_o | output | 1 | Serial data into memory |
| ee_do_i | input | 1 | Serial data from memory |

## Verification
A sequencer that leaves a phase early or late shows up within one serial pulse as a high or low phase of the wrong length, or as a pulse count other than 26 at done. A command register that shifts at the wrong moment moves data-in during a high phase or puts a wrong bit under one of the first nine rising edges, visible at that same edge. A data register that samples on the wrong cycle or in the wrong order only becomes visible at done, as a word that differs from what the memory model presented.

// File: rtl/ewr_pkg.sv
package ewr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_LEAD,
      ST_CMD,
      ST_DATA,
      ST_TAIL
   } ewr_state_e;

endpackage

// File: rtl/ewr_slot_timer.sv
module ewr_slot_timer
   import ewr_pkg::*;
#(
   parameter int TICK_CLKS = 4,
   parameter int HI_UNITS  = 3,
   parameter int LO_UNITS  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  ewr_state_e st,
   output logic       phase_hi,
   output logic       hi_end,
   output logic       slot_end
);

   localparam int SEL_CLKS  = TICK_CLKS;
   localparam int LEAD_CLKS = LO_UNITS * TICK_CLKS;
   localparam int HI_CLKS   = HI_UNITS * TICK_CLKS;
   localparam int SLOT_CLKS = (HI_UNITS + LO_UNITS) * TICK_CLKS;
   localparam int CNT_W     = $clog2(SLOT_CLKS);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   always_comb begin
      case (st)
         ST_SEL:  limit = CNT_W'(SEL_CLKS - 1);
         ST_LEAD: limit = CNT_W'(LEAD_CLKS - 1);
         default: limit = CNT_W'(SLOT_CLKS - 1);
      endcase
   end

   assign slot_end = (cnt_q == limit);
   assign hi_end   = (cnt_q == CNT_W'(HI_CLKS - 1));
   assign phase_hi = (cnt_q < CNT_W'(HI_CLKS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (st == ST_IDLE || slot_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ewr_sequencer.sv
module ewr_sequencer
   import ewr_pkg::*;
#(
   parameter int CMD_BITS  = 9,
   parameter int DATA_BITS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       hi_end,
   input  logic       slot_end,
   output ewr_state_e st,
   output logic       load_cmd,
   output logic       shift_cmd,
   output logic       sample,
   output logic       finish,
   output logic       done_o
);

   localparam int MAX_BITS = (CMD_BITS > DATA_BITS) ? CMD_BITS : DATA_BITS;
   localparam int BIT_W    = $clog2(MAX_BITS);

   ewr_state_e       st_q, st_d;
   logic [BIT_W-1:0] bit_q, bit_d;
   logic             done_q;

   assign st        = st_q;
   assign done_o    = done_q;
   assign load_cmd  = (st_q == ST_IDLE) && start_i;
   assign shift_cmd = (st_q == ST_CMD) && hi_end;
   assign sample    = (st_q == ST_DATA) && hi_end;
   assign finish    = (st_q == ST_TAIL) && slot_end;

   always_comb begin
      st_d  = st_q;
      bit_d = bit_q;
      case (st_q)
         ST_IDLE: if (start_i) st_d = ST_SEL;
         ST_SEL:  if (slot_end) st_d = ST_LEAD;
         ST_LEAD: if (slot_end) begin
            st_d  = ST_CMD;
            bit_d = '0;
         end
         ST_CMD: if (slot_end) begin
            if (bit_q == BIT_W'(CMD_BITS - 1)) begin
               st_d  = ST_DATA;
               bit_d = '0;
            end else begin
               bit_d = bit_q + 1'b1;
            end
         end
         ST_DATA: if (slot_end) begin
            if (bit_q == BIT_W'(DATA_BITS - 1)) begin
               st_d  = ST_TAIL;
               bit_d = '0;
            end else begin
               bit_d = bit_q + 1'b1;
            end
         end
         ST_TAIL: if (slot_end) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         bit_q  <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         bit_q  <= bit_d;
         done_q <= finish;
      end
   end

endmodule

// File: rtl/ewr_shifter.sv
module ewr_shifter #(
   parameter int                OP_W      = 3,
   parameter int                ADDR_W    = 6,
   parameter int                DATA_BITS = 16,
   parameter logic [OP_W-1:0]   READ_OP   = 3'b110
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_cmd,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 shift_cmd,
   input  logic                 sample,
   input  logic                 finish,
   input  logic                 ee_do_i,
   output logic                 cmd_msb,
   output logic [DATA_BITS-1:0] word_o
);

   localparam int CMD_BITS = OP_W + ADDR_W;

   logic [CMD_BITS-1:0]  cmd_q;
   logic [DATA_BITS-1:0] acc_q;
   logic [DATA_BITS-1:0] word_q;

   assign cmd_msb = cmd_q[CMD_BITS-1];
   assign word_o  = word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (load_cmd) begin
         cmd_q <= {READ_OP, addr_i};
      end else if (shift_cmd) begin
         cmd_q <= {cmd_q[CMD_BITS-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (sample) begin
         acc_q <= {acc_q[DATA_BITS-2:0], ee_do_i};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (finish) begin
         word_q <= acc_q;
      end
   end

endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
   import ewr_pkg::*;
#(
   parameter int              TICK_CLKS = 4,
   parameter int              HI_UNITS  = 3,
   parameter int              LO_UNITS  = 2,
   parameter int              OP_W      = 3,
   parameter int              ADDR_W    = 6,
   parameter int              DATA_W    = 16,
   parameter logic [OP_W-1:0] READ_OP   = 3'b110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] word_o,
   output logic              ee_cs_o,
   output logic              ee_sk_o,
   output logic              ee_di_o,
   input  logic              ee_do_i
);

   localparam int CMD_BITS = OP_W + ADDR_W;

   initial begin
      assert (TICK_CLKS >= 1) else $error("TICK_CLKS must be at least 1");
      assert (HI_UNITS >= 1)  else $error("HI_UNITS must be at least 1");
      assert (LO_UNITS >= 1)  else $error("LO_UNITS must be at least 1");
      assert (CMD_BITS >= 2)  else $error("command must be at least 2 bits");
      assert (DATA_W >= 2)    else $error("DATA_W must be at least 2");
   end

   ewr_state_e st;
   logic       phase_hi, hi_end, slot_end;
   logic       load_cmd, shift_cmd, sample, finish;
   logic       cmd_msb;

   ewr_slot_timer #(
      .TICK_CLKS(TICK_CLKS),
      .HI_UNITS (HI_UNITS),
      .LO_UNITS (LO_UNITS)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .st      (st),
      .phase_hi(phase_hi),
      .hi_end  (hi_end),
      .slot_end(slot_end)
   );

   ewr_sequencer #(
      .CMD_BITS (CMD_BITS),
      .DATA_BITS(DATA_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .hi_end   (hi_end),
      .slot_end (slot_end),
      .st       (st),
      .load_cmd (load_cmd),
      .shift_cmd(shift_cmd),
      .sample   (sample),
      .finish   (finish),
      .done_o   (done_o)
   );

   ewr_shifter #(
      .OP_W     (OP_W),
      .ADDR_W   (ADDR_W),
      .DATA_BITS(DATA_W),
      .READ_OP  (READ_OP)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_cmd (load_cmd),
      .addr_i   (addr_i),
      .shift_cmd(shift_cmd),
      .sample   (sample),
      .finish   (finish),
      .ee_do_i  (ee_do_i),
      .cmd_msb  (cmd_msb),
      .word_o   (word_o)
   );

   assign busy_o  = (st != ST_IDLE);
   assign ee_cs_o = (st == ST_SEL) || (st == ST_LEAD) ||
                    (st == ST_CMD) || (st == ST_DATA);
   assign ee_sk_o = ((st == ST_CMD) || (st == ST_DATA) || (st == ST_TAIL)) && phase_hi;
   assign ee_di_o = ((st == ST_LEAD) || (st == ST_CMD)) && cmd_msb;

endmodule

// File: rtl/ewr_checker.sv
module ewr_checker #(
   parameter int TICK_CLKS = 4,
   parameter int HI_UNITS  = 3,
   parameter int CMD_BITS  = 9,
   parameter int DATA_W    = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic [DATA_W-1:0] word_o,
   input logic              ee_cs_o,
   input logic              ee_sk_o,
   input logic              ee_di_o
);

   localparam int HI_CLKS = HI_UNITS * TICK_CLKS;
   localparam int PULSES  = CMD_BITS + DATA_W + 1;
   localparam int RUN_W   = $clog2(HI_CLKS + 1) + 1;
   localparam int RISE_W  = $clog2(PULSES + 1) + 1;

   logic [RUN_W-1:0]  hi_run;
   logic [RISE_W-1:0] rise_cnt;
   logic              sk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_run   <= '0;
         rise_cnt <= '0;
         sk_q     <= 1'b0;
      end else begin
         sk_q     <= ee_sk_o;
         hi_run   <= ee_sk_o ? hi_run + 1'b1 : '0;
         if (!busy_o)
            rise_cnt <= '0;
         else if (ee_sk_o && !sk_q)
            rise_cnt <= rise_cnt + 1'b1;
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!ee_cs_o && !ee_sk_o && !ee_di_o));

   assert_select_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_cs_o) |-> (!ee_sk_o && !ee_di_o));

   assert_di_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o));

   assert_high_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_sk_o) |-> (hi_run == RUN_W'(HI_CLKS)));

   assert_pulse_total_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (rise_cnt == RISE_W'(PULSES)));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(word_o));

endmodule

bind ee_word_reader ewr_checker #(
   .TICK_CLKS(TICK_CLKS),
   .HI_UNITS (HI_UNITS),
   .CMD_BITS (OP_W + ADDR_W),
   .DATA_W   (DATA_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy_o (busy_o),
   .done_o (done_o),
   .word_o (word_o),
   .ee_cs_o(ee_cs_o),
   .ee_sk_o(ee_sk_o),
   .ee_di_o(ee_di_o)
);

// File: tb/sim_ee_word_reader.sv
module sim_ee_word_reader;

   localparam int CLK_PERIOD = 10;
   localparam int TICK       = 3;
   localparam int HI         = 3;
   localparam int LO         = 2;
   localparam int WD_LIMIT   = 100000;
   localparam int NVEC       = 6;
   localparam logic [21:0] VEC [NVEC] = '{
      {6'h00, 16'h03F0},
      {6'h3F, 16'hFC0F},
      {6'h15, 16'h56A5},
      {6'h2A, 16'hA95A},
      {6'h01, 16'h07E1},
      {6'h20, 16'h81F0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  addr = '0;
   logic        busy, done, ee_cs, ee_sk, ee_di;
   logic        ee_do = 1'b0;
   logic [15:0] word;

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   ee_word_reader #(
      .TICK_CLKS(TICK), .HI_UNITS(HI), .LO_UNITS(LO)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
      .busy_o(busy), .done_o(done), .word_o(word),
      .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .ee_do_i(ee_do)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] mem_word(input logic [5:0] a);
      return {a, ~a, a[3:0]};
   endfunction

   // memory model
   int         m_rise = 0;
   logic [5:0] m_addr = '0;
   always @(posedge ee_sk or negedge ee_cs) begin
      if (!ee_cs) begin
         m_rise = 0;
         ee_do  = 1'b0;
      end else begin
         logic [15:0] w;
         m_rise = m_rise + 1;
         if (m_rise >= 4 && m_rise <= 9) m_addr = {m_addr[4:0], ee_di};
         w = mem_word(m_addr);
         if (m_rise >= 10 && m_rise <= 25) ee_do = w[25 - m_rise];
         else ee_do = 1'b0;
      end
   end

   // port monitor, sampled on the falling clock edge
   logic       p_sk = 0, p_cs = 0, p_di = 0, seen_rise = 0;
   logic [8:0] cap_cmd = '0;
   int r_hi = 0, r_lo = 0, hi_run = 0, lo_run = 0, setup_run = 0;
   int e_setup = 0, e_hold = 0, e_hi = 0, e_lo = 0, e_late = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ee_cs && !p_cs) begin
            if (ee_sk || ee_di) e_setup++;
            setup_run = 0;
            seen_rise = 0;
         end
         if (ee_cs && !seen_rise && !ee_sk) setup_run++;
         if (ee_sk && !p_sk) begin
            if (ee_cs) begin
               r_hi++;
               if (r_hi <= 9) cap_cmd = {cap_cmd[7:0], ee_di};
            end else begin
               r_lo++;
            end
            if (!seen_rise) begin
               seen_rise = 1;
               if (setup_run < TICK) e_setup++;
            end else if (lo_run != LO*TICK) begin
               e_lo++;
            end
            hi_run = 1;
         end else if (ee_sk) begin
            hi_run++;
            if (ee_di != p_di) e_hold++;
         end
         if (!ee_sk && p_sk) begin
            if (hi_run != HI*TICK) e_hi++;
            lo_run = 1;
         end else if (!ee_sk) begin
            lo_run++;
         end
         if ((r_hi > 9 || (r_hi == 9 && !ee_sk)) && ee_di) e_late++;
      end
      p_sk = ee_sk;
      p_cs = ee_cs;
      p_di = ee_di;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_mon();
      r_hi = 0; r_lo = 0; cap_cmd = '0;
      e_setup = 0; e_hold = 0; e_hi = 0; e_lo = 0; e_late = 0;
   endtask

   // one access; a second start with inj_addr is pulsed at cycle inj_at (-1: none)
   task automatic run_access(input logic [5:0] a, input logic [15:0] exp,
                             input int inj_at, input logic [5:0] inj_addr);
      int n = 0;
      int e_busy = 0;
      clear_mon();
      @(negedge clk);
      start = 1'b1;
      addr  = a;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
      while (!done && n < 5000) begin
         if (!busy) e_busy++;
         if (n == inj_at) begin
            start = 1'b1;
            addr  = inj_addr;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      chk(done == 1'b1, "R9", "done seen", int'(done), 1);
      chk(busy == 1'b0, "R9", "busy low at done", int'(busy), 0);
      chk(e_busy == 0, "R9", "busy dropped early", e_busy, 0);
      chk(word == exp, "R7", "word", int'(word), int'(exp));
      @(negedge clk);
      chk(done == 1'b0, "R9", "done width", int'(done), 0);
      chk(cap_cmd == {3'b110, a}, "R3", "command", int'(cap_cmd), int'({3'b110, a}));
      chk(r_hi == 25, "R8", "pulses selected", r_hi, 25);
      chk(r_lo == 1, "R8", "pulses deselected", r_lo, 1);
      chk(e_setup == 0, "R2", "select setup", e_setup, 0);
      chk(e_hold == 0, "R4", "di moved in high", e_hold, 0);
      chk(e_hi == 0, "R5", "high length", e_hi, 0);
      chk(e_lo == 0, "R5", "low length", e_lo, 0);
      chk(e_late == 0, "R6", "di after command", e_late, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual %0d expected below %0d", cyc, WD_LIMIT);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      start = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset state, start held high during reset
      chk(!ee_cs && !ee_sk && !ee_di, "R1", "lines in reset", {ee_cs, ee_sk, ee_di}, 0);
      chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
      chk(word == 16'h0, "R1", "word in reset", int'(word), 0);
      start = 1'b0;
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(!busy && !ee_cs && !ee_sk, "R1", "idle after reset", {busy, ee_cs, ee_sk}, 0);

      // table of addresses and expected words (R3 R7)
      for (int i = 0; i < NVEC; i++)
         run_access(VEC[i][21:16], VEC[i][15:0], -1, 6'h0);

      // R10: start with another address while busy
      run_access(6'h15, 16'h56A5, 200, 6'h3F);
      run_access(6'h2A, 16'hA95A, 3, 6'h00);

      // R1: reset in the middle of an access clears the word
      @(negedge clk);
      start = 1'b1;
      addr  = 6'h3F;
      @(negedge clk);
      start = 1'b0;
      repeat (150) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(!ee_cs && !ee_sk && !ee_di && !busy, "R1", "mid-access reset",
          {ee_cs, ee_sk, ee_di, busy}, 0);
      chk(word == 16'h0, "R1", "word cleared by reset", int'(word), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      run_access(6'h20, 16'h81F0, -1, 6'h0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule